// File: doc/BRIEF.md
# Parallel Configuration Port Master

This block drives the byte-wide slave-parallel configuration port of a programmable target device. On a load request it pulses the target's program-reset, waits for the target to report that it has cleared its configuration memory, then sets up the port and clocks a bitstream into it. The bitstream arrives one byte at a time on a valid/ready stream, and the last byte is flagged. Once the final byte is in, the block keeps clocking the port until the target reports completion.

Each wait on the target is bounded by a cycle limit. If the limit expires, the block pulses an abort output and reports a timeout. A readback request instead holds the byte lanes in high impedance, clocks the port a requested number of times, and delivers each captured byte on a valid output stream.

The clock half-period, the wait limit, the readback count width and the per-byte busy handling are parameters. Status flags stay unchanged until the next start request.

Top module: `cfg_par_loader`

## Requirements
- R1: After reset, program-reset, chip select and write-enable are deasserted. The configuration clock is high, the data output is enabled, `ld_ready` and `rb_valid` are low, and `op_active`, `op_ok` and `op_timeout` are all 0. Every port control is active-high: a 1 means asserted.
- R2: A load (`mode`=0 at `start`) asserts `cfg_prog` and then releases it. Chip select and write-enable stay deasserted until `cfg_init` has been seen high after that release.
- R3: In a load, write-enable is asserted before chip select rises. Write-enable is high at every moment chip select is asserted with the output enabled.
- R4: Each accepted load byte is driven on `cfg_dout` and held stable while the clock falls and rises again. Bytes reach the port in stream order, one capturing rising edge per byte.
- R5: With `BUSY_CHECK`=1, after the rising edge of a byte the block keeps adding clock pulses while `cfg_busy` is high. It offers no new byte until `cfg_busy` is low.
- R6: After the byte flagged `ld_last`, chip select drops while write-enable is still high, and write-enable drops afterwards. The block then pulses the clock until `cfg_done` is high, and sets `op_ok`.
- R7: If `cfg_init` does not go high within `WAIT_CYC` cycles after program-reset is released, `cfg_abort` pulses, `op_timeout` is set, and chip select is never asserted.
- R8: If `cfg_busy` stays high for `WAIT_CYC` cycles during the extra clocking, the load ends with an abort pulse and `op_timeout`.
- R9: If `cfg_done` does not rise within `WAIT_CYC` cycles of its wait starting, the load ends with an abort pulse and `op_timeout`.
- R10: A readback (`mode`=1 at `start`) drops `cfg_doe` and asserts chip select with write-enable low. It gives `rb_count` clock pulses and presents the `cfg_din` value captured after each rising edge on `rb_data` with a one-cycle `rb_valid`.
- R11: After the readback bytes, chip select drops, exactly one more clock pulse follows, and `op_ok` is set.
- R12: A readback with `rb_count`=0 captures no byte. It still gives one clock pulse after chip select drops, and completes with `op_ok`.
- R13: `op_ok` and `op_timeout` keep their value after an operation ends. Both are cleared, and `op_active` is set, on the cycle after the next `start`. They are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| mode | input | 1 | 0 = load, 1 = readback, sampled with start |
| rb_count | input | CNT_W | Number of readback bytes |
| ld_data | input | 8 | Load byte |
| ld_valid | input | 1 | Load byte valid |
| ld_last | input | 1 | Marks the final load byte |
| ld_ready | output | 1 | Load byte accepted this cycle when valid |
| rb_data | output | 8 | Captured readback byte |
| rb_valid | output | 1 | One-cycle strobe for rb_data |
| cfg_prog | output | 1 | Program-reset to target |
| cfg_cs | output | 1 | Chip select to target |
| cfg_we | output | 1 | Write-enable to target |
| cfg_cclk | output | 1 | Configuration clock |
| cfg_dout | output | 8 | Byte lanes toward target |
| cfg_doe | output | 1 | Output enable for cfg_dout (0 = high impedance) |
| cfg_init | input | 1 | Target ready after program-reset |
| cfg_busy | input | 1 | Target busy |
| cfg_done | input | 1 | Target configuration complete |
| cfg_din | input | 8 | Byte lanes from target |
| cfg_abort | output | 1 | One-cycle abort pulse on timeout |
| op_active | output | 1 | Operation in progress |
| op_ok | output | 1 | Last operation completed |
| op_timeout | output | 1 | Last operation ended on a timeout |

## Verification
A behavioural target model answers program-reset with a delayed init. It can raise busy for three extra clock pulses after a chosen byte, and raise done after a chosen number of trailing pulses. The scoreboard matches every byte the model captures against the accepted stream.

Loads with and without the busy episode, and with gaps in the valid stream, separate correct extra clocking from lost or duplicated bytes. Three stuck targets, one for each of init, busy and done, each trigger their own timeout path. Readbacks of five bytes and of zero bytes separate the capture timing from the single trailing pulse.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [4:0] {
        ST_IDLE, ST_PROG, ST_WINIT, ST_CS, ST_DATA, ST_LOW, ST_HIGH, ST_POST,
        ST_BHIGH, ST_WEOFF, ST_DWAIT, ST_DLOW, ST_RCS, ST_RLOW, ST_RHIGH,
        ST_RCAP, ST_RCSOFF, ST_RLOWT, ST_RHIGHT
    } state_e;

    typedef enum logic [1:0] {PH_NONE, PH_INIT, PH_BUSY, PH_DONE} wait_e;

    typedef struct packed {
        logic              prog;
        logic              cs;
        logic              we;
        logic              cclk;
        logic              doe;
        logic [BYTE_W-1:0] dout;
    } pins_t;

    localparam pins_t PINS_IDLE = '{prog: 1'b0, cs: 1'b0, we: 1'b0,
                                    cclk: 1'b1, doe: 1'b1, dout: '0};

    // Which bounded wait, if any, a state belongs to
    function automatic wait_e wait_of(state_e s);
        case (s)
            ST_WINIT:           return PH_INIT;
            ST_POST, ST_BHIGH:  return PH_BUSY;
            ST_DWAIT, ST_DLOW:  return PH_DONE;
            default:            return PH_NONE;
        endcase
    endfunction

endpackage

// File: rtl/cfgp_pace.sv
module cfgp_pace #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (HALF_CYC <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(HALF_CYC);
            logic [PW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || tick) cnt <= '0;
                else             cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == PW'(HALF_CYC - 1));
        end
    endgenerate
endmodule

// File: rtl/cfgp_wdog.sv
module cfgp_wdog #(
    parameter int LIMIT = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    logic [W-1:0] cnt;

    assign expired = (cnt == W'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clr)          cnt <= '0;
        else if (en && !expired) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cfg_par_loader.sv
module cfg_par_loader
    import cfgp_pkg::*;
#(
    parameter int HALF_CYC   = 2,
    parameter int WAIT_CYC   = 500000,
    parameter bit BUSY_CHECK = 1'b1,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode,
    input  logic [CNT_W-1:0]  rb_count,
    input  logic [BYTE_W-1:0] ld_data,
    input  logic              ld_valid,
    input  logic              ld_last,
    output logic              ld_ready,
    output logic [BYTE_W-1:0] rb_data,
    output logic              rb_valid,
    output logic              cfg_prog,
    output logic              cfg_cs,
    output logic              cfg_we,
    output logic              cfg_cclk,
    output logic [BYTE_W-1:0] cfg_dout,
    output logic              cfg_doe,
    input  logic              cfg_init,
    input  logic              cfg_busy,
    input  logic              cfg_done,
    input  logic [BYTE_W-1:0] cfg_din,
    output logic              cfg_abort,
    output logic              op_active,
    output logic              op_ok,
    output logic              op_timeout
);
    state_e            state;
    pins_t             pin;
    wait_e             phase_q;
    logic              tick, expired, tmr_clr, tmo_hit, last_q;
    logic [CNT_W-1:0]  rem;
    logic [BYTE_W-1:0] rb_q;
    logic              rbv_q, abort_q, act_q, ok_q, tmo_q;

    cfgp_pace #(.HALF_CYC(HALF_CYC)) u_pace (.clk(clk), .rst(rst), .tick(tick));

    assign tmr_clr = (wait_of(state) != phase_q);
    assign tmo_hit = expired && (wait_of(state) != PH_NONE) && !tmr_clr;

    cfgp_wdog #(.LIMIT(WAIT_CYC)) u_wdog (
        .clk(clk), .rst(rst), .clr(tmr_clr),
        .en(wait_of(state) != PH_NONE), .expired(expired)
    );

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_NONE;
        else     phase_q <= wait_of(state);
    end

    assign ld_ready = (state == ST_DATA) && tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pin     <= PINS_IDLE;
            last_q  <= 1'b0;
            rem     <= '0;
            rb_q    <= '0;
            rbv_q   <= 1'b0;
            abort_q <= 1'b0;
            act_q   <= 1'b0;
            ok_q    <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            rbv_q   <= 1'b0;
            abort_q <= 1'b0;
            if (tmo_hit) begin
                state    <= ST_IDLE;
                pin.prog <= 1'b0;
                pin.cs   <= 1'b0;
                pin.we   <= 1'b0;
                pin.cclk <= 1'b1;
                pin.doe  <= 1'b1;
                abort_q  <= 1'b1;
                tmo_q    <= 1'b1;
                act_q    <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: if (start) begin
                        act_q <= 1'b1;
                        ok_q  <= 1'b0;
                        tmo_q <= 1'b0;
                        rem   <= rb_count;
                        if (mode) begin
                            pin.doe <= 1'b0;
                            state   <= ST_RCS;
                        end else begin
                            pin.prog <= 1'b1;
                            state    <= ST_PROG;
                        end
                    end
                    ST_PROG: if (tick) begin
                        pin.prog <= 1'b0;
                        state    <= ST_WINIT;
                    end
                    ST_WINIT: if (tick && cfg_init) begin
                        pin.we <= 1'b1;
                        state  <= ST_CS;
                    end
                    ST_CS: if (tick) begin
                        pin.cs   <= 1'b1;
                        pin.cclk <= 1'b1;
                        state    <= ST_DATA;
                    end
                    ST_DATA: if (ld_ready && ld_valid) begin
                        pin.dout <= ld_data;
                        last_q   <= ld_last;
                        state    <= ST_LOW;
                    end
                    ST_LOW: if (tick) begin
                        pin.cclk <= 1'b0;
                        state    <= ST_HIGH;
                    end
                    ST_HIGH: if (tick) begin
                        pin.cclk <= 1'b1;
                        state    <= ST_POST;
                    end
                    ST_POST: if (tick) begin
                        if (BUSY_CHECK && cfg_busy) begin
                            pin.cclk <= 1'b0;
                            state    <= ST_BHIGH;
                        end else if (last_q) begin
                            pin.cs <= 1'b0;
                            state  <= ST_WEOFF;
                        end else begin
                            state <= ST_DATA;
                        end
                    end
                    ST_BHIGH: if (tick) begin
                        pin.cclk <= 1'b1;
                        state    <= ST_POST;
                    end
                    ST_WEOFF: if (tick) begin
                        pin.we <= 1'b0;
                        state  <= ST_DWAIT;
                    end
                    ST_DWAIT: if (tick) begin
                        if (cfg_done) begin
                            ok_q  <= 1'b1;
                            act_q <= 1'b0;
                            state <= ST_IDLE;
                        end else begin
                            pin.cclk <= 1'b0;
                            state    <= ST_DLOW;
                        end
                    end
                    ST_DLOW: if (tick) begin
                        pin.cclk <= 1'b1;
                        state    <= ST_DWAIT;
                    end
                    ST_RCS: if (tick) begin
                        pin.cs   <= 1'b1;
                        pin.cclk <= 1'b1;
                        state    <= (rem == '0) ? ST_RCSOFF : ST_RLOW;
                    end
                    ST_RLOW: if (tick) begin
                        pin.cclk <= 1'b0;
                        state    <= ST_RHIGH;
                    end
                    ST_RHIGH: if (tick) begin
                        pin.cclk <= 1'b1;
                        state    <= ST_RCAP;
                    end
                    ST_RCAP: begin
                        rb_q  <= cfg_din;
                        rbv_q <= 1'b1;
                        rem   <= rem - 1'b1;
                        state <= (rem == CNT_W'(1)) ? ST_RCSOFF : ST_RLOW;
                    end
                    ST_RCSOFF: if (tick) begin
                        pin.cs <= 1'b0;
                        state  <= ST_RLOWT;
                    end
                    ST_RLOWT: if (tick) begin
                        pin.cclk <= 1'b0;
                        state    <= ST_RHIGHT;
                    end
                    ST_RHIGHT: if (tick) begin
                        pin.cclk <= 1'b1;
                        pin.doe  <= 1'b1;
                        ok_q     <= 1'b1;
                        act_q    <= 1'b0;
                        state    <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign cfg_prog   = pin.prog;
    assign cfg_cs     = pin.cs;
    assign cfg_we     = pin.we;
    assign cfg_cclk   = pin.cclk;
    assign cfg_dout   = pin.dout;
    assign cfg_doe    = pin.doe;
    assign rb_data    = rb_q;
    assign rb_valid   = rbv_q;
    assign cfg_abort  = abort_q;
    assign op_active  = act_q;
    assign op_ok      = ok_q;
    assign op_timeout = tmo_q;
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_prog,
    input logic       cfg_cs,
    input logic       cfg_we,
    input logic       cfg_cclk,
    input logic [7:0] cfg_dout,
    input logic       cfg_doe,
    input logic       cfg_abort,
    input logic       rb_valid,
    input logic       ld_ready,
    input logic       op_active,
    input logic       op_ok,
    input logic       op_timeout
);
    p_we_covers_cs_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_cs && cfg_doe) |-> cfg_we);

    p_dout_held_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(cfg_cclk) && cfg_cs && cfg_we) |-> $stable(cfg_dout));

    p_ready_in_window_r4: assert property (@(posedge clk) disable iff (rst)
        ld_ready |-> (cfg_cs && cfg_we && !cfg_prog));

    p_prog_alone_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_prog |-> (!cfg_cs && !cfg_we));

    p_abort_state_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_abort |-> (op_timeout && !cfg_cs && !cfg_we && !op_active));

    p_rb_hiz_r10: assert property (@(posedge clk) disable iff (rst)
        rb_valid |-> (!cfg_doe && !cfg_we && cfg_cs));

    p_flags_excl_r13: assert property (@(posedge clk) disable iff (rst)
        !(op_ok && op_timeout));

    p_active_clean_r13: assert property (@(posedge clk) disable iff (rst)
        op_active |-> (!op_ok && !op_timeout));
endmodule

bind cfg_par_loader cfgp_chk u_chk (
    .clk(clk), .rst(rst), .cfg_prog(cfg_prog), .cfg_cs(cfg_cs), .cfg_we(cfg_we),
    .cfg_cclk(cfg_cclk), .cfg_dout(cfg_dout), .cfg_doe(cfg_doe),
    .cfg_abort(cfg_abort), .rb_valid(rb_valid), .ld_ready(ld_ready),
    .op_active(op_active), .op_ok(op_ok), .op_timeout(op_timeout)
);

// File: tb/sim_cfg_par_loader.sv
module sim_cfg_par_loader;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, mode = 1'b0;
    logic [CW-1:0] rb_count = '0;
    logic [7:0] ld_data = '0;
    logic ld_valid = 1'b0, ld_last = 1'b0;
    logic ld_ready, rb_valid, cfg_prog, cfg_cs, cfg_we, cfg_cclk, cfg_doe;
    logic cfg_abort, op_active, op_ok, op_timeout;
    logic [7:0] rb_data, cfg_dout;
    logic init_r = 1'b0, busy_r = 1'b0, done_r = 1'b0;
    logic [7:0] din_r = '0;

    always #10 clk = ~clk;

    cfg_par_loader #(.HALF_CYC(2), .WAIT_CYC(300), .BUSY_CHECK(1'b1), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .rb_count(rb_count),
        .ld_data(ld_data), .ld_valid(ld_valid), .ld_last(ld_last), .ld_ready(ld_ready),
        .rb_data(rb_data), .rb_valid(rb_valid), .cfg_prog(cfg_prog), .cfg_cs(cfg_cs),
        .cfg_we(cfg_we), .cfg_cclk(cfg_cclk), .cfg_dout(cfg_dout), .cfg_doe(cfg_doe),
        .cfg_init(init_r), .cfg_busy(busy_r), .cfg_done(done_r), .cfg_din(din_r),
        .cfg_abort(cfg_abort), .op_active(op_active), .op_ok(op_ok), .op_timeout(op_timeout)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit good, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // target model and scoreboard state
    byte q_ld[$];
    byte q_rb[$];
    int  init_cnt, busy_left, ld_caps, ld_rises, post_rises, rb_rises, rb_got;
    int  busy_at, done_after;
    bit  init_never, busy_stuck, cs_seen, saw_prog, saw_abort, cs_early;
    bit  we_order_bad, cs_off_bad, we_in_rb, doe_low_seen;
    logic cclk_q = 1'b1, cs_q = 1'b0, we_q = 1'b0;

    function automatic logic [7:0] rb_pat(input int k);
        return 8'h5A + 8'(k * 37);
    endfunction

    task automatic model_clear(input int b_at, input bit stuck, input bit no_init,
                               input int d_after);
        @(posedge clk);
        busy_at = b_at; busy_stuck = stuck; init_never = no_init; done_after = d_after;
        init_cnt = 0; busy_left = 0; ld_caps = 0; ld_rises = 0; post_rises = 0;
        rb_rises = 0; rb_got = 0; cs_seen = 0; saw_prog = 0; saw_abort = 0;
        cs_early = 0; we_order_bad = 0; cs_off_bad = 0; we_in_rb = 0; doe_low_seen = 0;
        busy_r = 1'b0; done_r = 1'b0;
        q_ld.delete(); q_rb.delete();
    endtask

    // monitor: target model plus scoreboard comparison
    always @(negedge clk) begin
        if (!rst) begin
            if (cfg_prog) begin
                saw_prog = 1; init_r = 1'b0; init_cnt = 0;
            end else if (!init_never && !init_r && saw_prog) begin
                init_cnt++;
                if (init_cnt >= 5) init_r = 1'b1;
            end
            if (cfg_abort) saw_abort = 1;
            if (cfg_cs && !cfg_doe) doe_low_seen = 1;
            if (!cfg_doe && cfg_we) we_in_rb = 1;
            if (cfg_cs && !cs_q) begin
                cs_seen = 1;
                if (cfg_doe) begin
                    if (!we_q) we_order_bad = 1;
                    if (!init_r) cs_early = 1;
                end
            end
            if (!cfg_cs && cs_q && cfg_doe && !cfg_abort && !cfg_we) cs_off_bad = 1;
            if (cfg_cclk && !cclk_q) begin
                if (cfg_cs && cfg_we) begin
                    ld_rises++;
                    if (!busy_r) begin
                        if (q_ld.size() == 0) chk(1'b0, "R4", "byte with empty queue", cfg_dout, -1);
                        else begin
                            automatic byte e = q_ld.pop_front();
                            chk(cfg_dout == 8'(e), "R4", "captured load byte", cfg_dout, 8'(e));
                        end
                        ld_caps++;
                        if (ld_caps == busy_at) begin busy_r = 1'b1; busy_left = 3; end
                    end else begin
                        busy_left--;
                        if (busy_left <= 0 && !busy_stuck) busy_r = 1'b0;
                    end
                end else if (cfg_cs && !cfg_we) begin
                    din_r = rb_pat(rb_rises);
                    rb_rises++;
                end else if (!cfg_cs && cs_seen) begin
                    post_rises++;
                    if (done_after > 0 && post_rises == done_after) done_r = 1'b1;
                end
            end
            if (rb_valid) begin
                rb_got++;
                if (q_rb.size() == 0) chk(1'b0, "R10", "readback with empty queue", rb_data, -1);
                else begin
                    automatic byte e = q_rb.pop_front();
                    chk(rb_data == 8'(e), "R10", "readback byte", rb_data, 8'(e));
                end
            end
        end
        cclk_q = cfg_cclk; cs_q = cfg_cs; we_q = cfg_we;
    end

    task automatic kick(input bit m, input int cnt);
        @(negedge clk);
        start = 1'b1; mode = m; rb_count = CW'(cnt);
        @(negedge clk);
        start = 1'b0;
        chk(op_active && !op_ok && !op_timeout, "R13", "flags cleared on start",
            {op_active, op_ok, op_timeout}, 3'b100);
    endtask

    task automatic wait_idle();
        while (op_active) @(negedge clk);
        @(negedge clk);
    endtask

    // driver: pushes expected bytes as the design accepts them
    task automatic run_load(input int n, input int seed, input bit gaps);
        kick(1'b0, 0);
        for (int i = 0; i < n; i++) begin
            ld_valid = 1'b1;
            ld_data  = 8'(i * 29 + seed);
            ld_last  = (i == n - 1);
            while (!ld_ready && op_active) @(negedge clk);
            if (!op_active) break;
            q_ld.push_back(byte'(ld_data));
            @(negedge clk);
            if (gaps && (i % 3 == 0)) begin
                ld_valid = 1'b0;
                repeat (3) @(negedge clk);
            end
        end
        ld_valid = 1'b0; ld_last = 1'b0;
        wait_idle();
    endtask

    task automatic run_rb(input int n);
        for (int k = 0; k < n; k++) q_rb.push_back(byte'(rb_pat(k)));
        kick(1'b1, n);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!cfg_prog && !cfg_cs && !cfg_we && cfg_cclk && cfg_doe, "R1", "port idle",
            {cfg_prog, cfg_cs, cfg_we, cfg_cclk, cfg_doe}, 5'b00011);
        chk(!ld_ready && !rb_valid && !op_active && !op_ok && !op_timeout, "R1",
            "stream and flags idle", {ld_ready, rb_valid, op_active, op_ok, op_timeout}, 0);

        // readback of five bytes
        model_clear(0, 0, 0, 0);
        run_rb(5);
        chk(op_ok && !op_timeout, "R11", "readback ok", op_ok, 1);
        chk(rb_rises == 5, "R10", "clock pulses under chip select", rb_rises, 5);
        chk(rb_got == 5, "R10", "bytes delivered", rb_got, 5);
        chk(doe_low_seen && !we_in_rb, "R10", "lanes released, write-enable low",
            {doe_low_seen, we_in_rb}, 2'b10);
        chk(post_rises == 1, "R11", "trailing pulse count", post_rises, 1);
        chk(cfg_doe, "R11", "output enable restored", cfg_doe, 1);

        // readback of zero bytes
        model_clear(0, 0, 0, 0);
        run_rb(0);
        chk(op_ok && rb_got == 0 && rb_rises == 0, "R12", "empty readback",
            rb_got + rb_rises, 0);
        chk(post_rises == 1, "R12", "trailing pulse on empty readback", post_rises, 1);

        repeat (40) @(negedge clk);
        chk(op_ok && !op_active, "R13", "ok held while idle", op_ok, 1);

        // load with a busy episode after the third byte
        model_clear(3, 0, 0, 4);
        run_load(12, 7, 0);
        chk(saw_prog && !cs_early, "R2", "program pulse, then init before select",
            {saw_prog, cs_early}, 2'b10);
        chk(!we_order_bad, "R3", "write-enable ahead of chip select", we_order_bad, 0);
        chk(ld_caps == 12 && q_ld.size() == 0, "R4", "all bytes captured", ld_caps, 12);
        chk(ld_rises == 15, "R5", "rises incl. busy extras", ld_rises, 15);
        chk(!cs_off_bad, "R6", "chip select dropped before write-enable", cs_off_bad, 0);
        chk(post_rises == 4, "R6", "pulses until done", post_rises, 4);
        chk(op_ok && !op_timeout && !saw_abort, "R6", "load ok", op_ok, 1);

        // load with valid gaps, no busy
        model_clear(0, 0, 0, 2);
        run_load(6, 101, 1);
        chk(ld_caps == 6 && ld_rises == 6, "R4", "gapped stream captures", ld_rises, 6);
        chk(post_rises == 2 && op_ok, "R6", "short done wait", post_rises, 2);

        // init never rises
        model_clear(0, 0, 1, 2);
        run_load(4, 3, 0);
        chk(op_timeout && !op_ok && saw_abort, "R7", "init timeout", op_timeout, 1);
        chk(!cs_seen, "R7", "no chip select after init timeout", cs_seen, 0);

        repeat (30) @(negedge clk);
        chk(op_timeout && !op_ok, "R13", "timeout held while idle", op_timeout, 1);

        // busy stuck after byte two
        model_clear(2, 1, 0, 2);
        run_load(5, 55, 0);
        chk(op_timeout && saw_abort, "R8", "busy timeout", op_timeout, 1);
        chk(ld_caps == 2, "R8", "bytes before stuck busy", ld_caps, 2);
        chk(!cfg_cs && !cfg_we, "R8", "port released", {cfg_cs, cfg_we}, 0);

        // done never rises
        model_clear(0, 0, 0, 0);
        run_load(3, 9, 0);
        chk(op_timeout && saw_abort && !op_ok, "R9", "done timeout", op_timeout, 1);
        chk(post_rises > 1 && ld_caps == 3, "R9", "clocking before done timeout", post_rises, 2);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule